// File: doc/BRIEF.md
# Timer Compare-Match Output Unit

This block is an up-counting timer with two compare channels, A and B. Each channel compares the running count against its own compare register. On an equal count, a per-channel 2-bit action code decides what happens to that channel's output latch: nothing, toggle, force low or force high. The counter runs either free, wrapping at the all-ones value, or in clear-on-compare mode. In clear-on-compare mode channel A's compare value is the top of the count.

Any nonzero action code hands the channel's pin from the general-purpose port value to the compare latch. The pin's output enable always follows its data-direction bit, so the pin is driven only when that bit is 1. Software reaches the block through a simple write port and a combinational read port. The waveform mode is 3 bits wide: two low bits in the first control register and the high bit in the second. Mode codes other than normal and clear-on-compare are run as normal counting.

Top module: `cmp_timer_unit`

## Requirements
- R1: After reset every register reads 0, the counter is 0, both output latches are 0, and each pin shows its port value.
- R2: Register map (3-bit address). Address 0 is control A: bits 7:6 hold the channel A action, bits 5:4 the channel B action, bits 1:0 the low waveform bits, and bits 3:2 always read 0 and ignore writes. Address 1 is control B: bit 3 holds the waveform high bit and all other bits read 0. Addresses 2 and 3 hold the A and B compare values. Address 4 reads the counter and ignores writes. Addresses 5 to 7 read 0.
- R3: With waveform code not 3'b010, each enabled clock adds 1 to the counter, wrapping from 0xFF to 0x00. Codes 1 and 3 to 7 count this way.
- R4: With waveform code 3'b010, an enabled clock at which the counter equals the channel A compare value loads 0. Otherwise the counter adds 1 and wraps from 0xFF to 0x00.
- R5: While the count enable is low, the counter and both latches hold their values.
- R6: A match is an enabled clock at which the counter equals the channel's compare value. With action code 1, the channel's latch toggles at that edge.
- R7: On a match, action code 2 clears the latch and action code 3 sets it. Code 0 leaves it unchanged.
- R8: With action code 0 the pin carries the port value. With a nonzero code it carries the latch. The latch keeps its state while disconnected and shows it again on reconnection.
- R9: Each pin's output enable equals its data-direction bit in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable (one count step per enabled clock) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Combinational read data |
| port_val | input | 2 | General-purpose port values, bit 0 for A, bit 1 for B |
| port_dir | input | 2 | Data-direction bits, bit 0 for A, bit 1 for B |
| pin_out | output | 2 | Pin output values |
| pin_oe | output | 2 | Pin output enables |

## Verification
Three events can land on one clock edge. In clear-on-compare mode, the counter reset to 0 can coincide with channel A's output action. When both compare registers hold the same value, channel B's action also falls on that edge. The bench provokes this by sweeping all sixteen pairs of action codes in both counting modes, with equal compare values on every fourth pair. At each edge it checks the counter and both pins against a bench-side model that applies the action from the pre-edge count and then clears. A pulse-train count enable also puts disabled clocks on matching counts, to show that no action is taken there.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ACT_OFF    = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_CLEAR  = 2'd2,
    ACT_SET    = 2'd3
  } act_e;

  localparam logic [2:0] WAVE_CTC  = 3'b010;
  localparam int         ADDR_W    = 3;
  localparam logic [2:0] ADDR_CTLA = 3'd0;
  localparam logic [2:0] ADDR_CTLB = 3'd1;
  localparam logic [2:0] ADDR_CMPA = 3'd2;
  localparam logic [2:0] ADDR_CMPB = 3'd3;
  localparam logic [2:0] ADDR_CNT  = 3'd4;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DW     = 8,
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DW-1:0]     cnt,
  output logic [DW-1:0]     rd_data,
  output logic [2*NUM_CH-1:0] mode_flat,
  output logic [2:0]        wave,
  output logic [DW*NUM_CH-1:0] cmp_flat
);
  logic [1:0]    mode_q [NUM_CH];
  logic [1:0]    mode_d [NUM_CH];
  logic [1:0]    wlo_q, wlo_d;
  logic          whi_q, whi_d;
  logic [DW-1:0] cmp_q  [NUM_CH];
  logic [DW-1:0] cmp_d  [NUM_CH];

  always_comb begin
    wlo_d = wlo_q;
    whi_d = whi_q;
    for (int c = 0; c < NUM_CH; c++) begin
      mode_d[c] = mode_q[c];
      cmp_d[c]  = cmp_q[c];
    end
    if (wr_en) begin
      case (wr_addr)
        ADDR_CTLA: begin
          mode_d[0] = wr_data[7:6];
          mode_d[1] = wr_data[5:4];
          wlo_d     = wr_data[1:0];
        end
        ADDR_CTLB: whi_d = wr_data[3];
        ADDR_CMPA: cmp_d[0] = wr_data;
        ADDR_CMPB: cmp_d[1] = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wlo_q <= '0;
      whi_q <= 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
        mode_q[c] <= '0;
        cmp_q[c]  <= '0;
      end
    end else begin
      wlo_q <= wlo_d;
      whi_q <= whi_d;
      for (int c = 0; c < NUM_CH; c++) begin
        mode_q[c] <= mode_d[c];
        cmp_q[c]  <= cmp_d[c];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_CTLA: rd_data[7:0] = {mode_q[0], mode_q[1], 2'b00, wlo_q};
      ADDR_CTLB: rd_data[3]   = whi_q;
      ADDR_CMPA: rd_data      = cmp_q[0];
      ADDR_CMPB: rd_data      = cmp_q[1];
      ADDR_CNT:  rd_data      = cnt;
      default:   rd_data      = '0;
    endcase
  end

  assign wave = {whi_q, wlo_q};

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_out
      assign mode_flat[2*g +: 2]  = mode_q[g];
      assign cmp_flat[DW*g +: DW] = cmp_q[g];
    end
  endgenerate
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             ctc,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) begin
      if (ctc && (cnt_q == top)) cnt_d = '0;
      else                       cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic [1:0]       mode,
  input  logic             port_val,
  input  logic             port_dir,
  output logic             lat,
  output logic             pin_out,
  output logic             pin_oe
);
  logic lat_q, lat_d;
  logic hit;
  act_e act;

  assign act = act_e'(mode);
  assign hit = cnt_en && (cnt == cmp);

  always_comb begin
    lat_d = lat_q;
    if (hit) begin
      case (act)
        ACT_TOGGLE: lat_d = ~lat_q;
        ACT_CLEAR:  lat_d = 1'b0;
        ACT_SET:    lat_d = 1'b1;
        default:    lat_d = lat_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= 1'b0;
    else        lat_q <= lat_d;
  end

  assign lat     = lat_q;
  assign pin_out = (act != ACT_OFF) ? lat_q : port_val;
  assign pin_oe  = port_dir;
endmodule

// File: rtl/cmp_timer_unit.sv
module cmp_timer_unit
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [2:0]        rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic [NUM_CH-1:0] port_val,
  input  logic [NUM_CH-1:0] port_dir,
  output logic [NUM_CH-1:0] pin_out,
  output logic [NUM_CH-1:0] pin_oe
);
  logic                      rst_i_n;
  logic [CNT_W-1:0]          cnt_q;
  logic [2*NUM_CH-1:0]       mode_flat;
  logic [CNT_W*NUM_CH-1:0]   cmp_flat;
  logic [2:0]                wave;
  logic [NUM_CH-1:0]         lat;
  logic                      ctc;

  tmr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  tmr_regs #(.DW(CNT_W), .NUM_CH(NUM_CH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .cnt       (cnt_q),
    .rd_data   (rd_data),
    .mode_flat (mode_flat),
    .wave      (wave),
    .cmp_flat  (cmp_flat)
  );

  assign ctc = (wave == WAVE_CTC);

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .cnt_en (cnt_en),
    .ctc    (ctc),
    .top    (cmp_flat[CNT_W-1:0]),
    .cnt    (cnt_q)
  );

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      tmr_cmp_chan #(.CNT_W(CNT_W)) u_ch (
        .clk      (clk),
        .rst_n    (rst_i_n),
        .cnt_en   (cnt_en),
        .cnt      (cnt_q),
        .cmp      (cmp_flat[CNT_W*g +: CNT_W]),
        .mode     (mode_flat[2*g +: 2]),
        .port_val (port_val[g]),
        .port_dir (port_dir[g]),
        .lat      (lat[g]),
        .pin_out  (pin_out[g]),
        .pin_oe   (pin_oe[g])
      );
    end
  endgenerate
endmodule

// File: rtl/tmr_timer_chk.sv
module tmr_timer_chk #(
  parameter int CNT_W  = 8,
  parameter int NUM_CH = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cnt_en,
  input logic [CNT_W-1:0]        cnt,
  input logic [2:0]              wave,
  input logic [CNT_W*NUM_CH-1:0] cmp_flat,
  input logic [2*NUM_CH-1:0]     mode_flat,
  input logic [NUM_CH-1:0]       lat,
  input logic [NUM_CH-1:0]       port_val,
  input logic [NUM_CH-1:0]       pin_out,
  input logic [2:0]              rd_addr,
  input logic [CNT_W-1:0]        rd_data
);
  a_r2_rsv_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 3'd0) |-> (rd_data[3:2] == 2'b00));

  a_r3_normal_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && wave != 3'b010) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  a_r4_ctc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && wave == 3'b010 && cnt == cmp_flat[CNT_W-1:0]) |=> (cnt == '0));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en) |=> ($stable(cnt) && $stable(lat)));

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
      a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && cnt == cmp_flat[CNT_W*g +: CNT_W] && mode_flat[2*g +: 2] == 2'd1)
        |=> (lat[g] != $past(lat[g])));

      a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && cnt == cmp_flat[CNT_W*g +: CNT_W] && mode_flat[2*g +: 2] == 2'd2)
        |=> (lat[g] == 1'b0));

      a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && cnt == cmp_flat[CNT_W*g +: CNT_W] && mode_flat[2*g +: 2] == 2'd3)
        |=> (lat[g] == 1'b1));

      a_r8_disconnected: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_flat[2*g +: 2] == 2'd0) |-> (pin_out[g] == port_val[g]));
    end
  endgenerate
endmodule

bind cmp_timer_unit tmr_timer_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_i_n),
  .cnt_en    (cnt_en),
  .cnt       (cnt_q),
  .wave      (wave),
  .cmp_flat  (cmp_flat),
  .mode_flat (mode_flat),
  .lat       (lat),
  .port_val  (port_val),
  .pin_out   (pin_out),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data)
);

// File: tb/test_cmp_timer_unit.sv
module test_cmp_timer_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cnt_en;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [2:0] rd_addr;
  logic [7:0] rd_data;
  logic [1:0] port_val;
  logic [1:0] port_dir;
  logic [1:0] pin_out;
  logic [1:0] pin_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [7:0] m_cnt;
  logic [1:0] m_lat;
  logic [1:0] m_mode [2];
  logic [7:0] m_cmp  [2];
  logic [1:0] m_wlo;
  logic       m_whi;
  string      ctx;

  always #4 clk = ~clk;

  cmp_timer_unit i_cmp_timer_unit (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .port_val(port_val), .port_dir(port_dir), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic check_state();
    rd_addr = 3'd4;
    #1;
    chk(ctx, int'(rd_data), int'(m_cnt));
    for (int c = 0; c < 2; c++) begin
      if (m_mode[c] == 2'd0) chk("R8 pin shows port", int'(pin_out[c]), int'(port_val[c]));
      else                   chk({ctx, " R8 pin shows latch"}, int'(pin_out[c]), int'(m_lat[c]));
      chk("R9 oe follows dir", int'(pin_oe[c]), int'(port_dir[c]));
    end
  endtask

  task automatic step(input logic en);
    cnt_en   = en;
    port_val = 2'($urandom);
    port_dir = 2'($urandom);
    @(posedge clk);
    if (en) begin
      for (int c = 0; c < 2; c++) begin
        if (m_cnt == m_cmp[c]) begin
          case (m_mode[c])
            2'd1: m_lat[c] = ~m_lat[c];
            2'd2: m_lat[c] = 1'b0;
            2'd3: m_lat[c] = 1'b1;
            default: ;
          endcase
        end
      end
      if ({m_whi, m_wlo} == 3'b010 && m_cnt == m_cmp[0]) m_cnt = 8'd0;
      else m_cnt = m_cnt + 8'd1;
    end
    #1;
    check_state();
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cnt_en  = 1'b0;
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(posedge clk);
    case (a)
      3'd0: begin m_mode[0] = d[7:6]; m_mode[1] = d[5:4]; m_wlo = d[1:0]; end
      3'd1: m_whi = d[3];
      3'd2: m_cmp[0] = d;
      3'd3: m_cmp[1] = d;
      default: ;
    endcase
    #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(req, int'(rd_data), int'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cnt_en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; port_val = 2'b10; port_dir = 2'b01;
    m_cnt = '0; m_lat = '0; m_wlo = '0; m_whi = 1'b0;
    for (int c = 0; c < 2; c++) begin m_mode[c] = '0; m_cmp[c] = '0; end
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    for (int a = 0; a < 8; a++) rd_chk("R1 reset readback", 3'(a), 8'h00);
    chk("R1 reset pins show port", int'(pin_out), 2);
    chk("R9 reset oe", int'(pin_oe), 1);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R2: register map, reserved bits, read-only counter
    wr(3'd0, 8'hFF); rd_chk("R2 ctrlA reserved bits read 0", 3'd0, 8'hF3);
    wr(3'd1, 8'hFF); rd_chk("R2 ctrlB only bit3", 3'd1, 8'h08);
    wr(3'd2, 8'h5A); rd_chk("R2 cmpA readback", 3'd2, 8'h5A);
    wr(3'd3, 8'hC3); rd_chk("R2 cmpB readback", 3'd3, 8'hC3);
    wr(3'd4, 8'h77); rd_chk("R2 counter ignores write", 3'd4, 8'h00);
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 8'hFF); rd_chk("R2 unused address reads 0", 3'(a), 8'h00);
    end
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);

    // R3: free counting with wrap, plus PWM-type codes run as normal
    ctx = "R3 normal count";
    for (int i = 0; i < 300; i++) step(1'b1);
    wr(3'd0, 8'h01);
    ctx = "R3 code 1 counts as normal";
    for (int i = 0; i < 260; i++) step(1'b1);
    wr(3'd0, 8'h03); wr(3'd1, 8'h08);
    ctx = "R3 code 7 counts as normal";
    for (int i = 0; i < 260; i++) step(1'b1);
    wr(3'd1, 8'h00); wr(3'd0, 8'h00);

    // R5: gated enable with toggle actions armed
    wr(3'd2, 8'd4); wr(3'd3, 8'd9); wr(3'd0, 8'h50);
    ctx = "R5 hold while disabled";
    for (int i = 0; i < 400; i++) step(logic'((i % 3) != 0));

    // R4: clear-on-compare with various tops
    wr(3'd0, 8'h02);
    foreach (m_cmp[k]) ;
    for (int t = 0; t < 5; t++) begin
      logic [7:0] tops [5] = '{8'd0, 8'd1, 8'd5, 8'd200, 8'd255};
      wr(3'd2, tops[t]);
      ctx = "R4 clear-on-compare";
      for (int i = 0; i < 300; i++) step(1'b1);
    end

    // R6, R7, R8: every action pair, both counting modes, coincident matches
    for (int w = 0; w < 2; w++) begin
      for (int combo = 0; combo < 16; combo++) begin
        logic [7:0] ca;
        logic [7:0] cb;
        ca = 8'(23 + combo * 13);
        cb = (combo % 4 == 0) ? ca : 8'(combo * 7);
        wr(3'd2, ca);
        wr(3'd3, cb);
        wr(3'd0, {2'(combo >> 2), 2'(combo), 2'b00, (w == 1) ? 2'b10 : 2'b00});
        ctx = (combo % 4 == 0) ? "R6 R7 coincident matches" : "R6 R7 match actions";
        for (int i = 0; i < 280; i++) step(logic'((i % 17) != 5));
      end
    end

    // R8: disconnect keeps latch, reconnect shows it
    wr(3'd0, 8'h40); wr(3'd2, 8'd10);
    ctx = "R8 toggle connected";
    for (int i = 0; i < 270; i++) step(1'b1);
    wr(3'd0, 8'h00);
    ctx = "R8 disconnected";
    for (int i = 0; i < 270; i++) step(1'b1);
    wr(3'd0, 8'h40);
    #1;
    chk("R8 reconnect shows held latch", int'(pin_out[0]), int'(m_lat[0]));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule